// File: doc/BRIEF.md
# Device Readiness Poll Engine

After a downstream function has been put through a function-level reset, this block decides when that function can safely be touched again. Software or a controller pulses `start_i`. The block then waits a mandatory settle period and reads the function's identifier register through a single-request configuration read port. It keeps retrying with a back-off delay that doubles each round until the function answers with a real identifier or the wait budget runs out.

Time is measured in ticks from `tick_i`, for example one tick per millisecond. The elapsed wait, including the settle period, is available at all times on `elapsed_o`. A one-cycle `progress_o` pulse marks every retry so that progress can be logged while the poll continues.

A final response that is ready wins over an expired budget, so a function that comes up on the very last read is reported ready. When the budget is spent, the block reports a timeout. It also flags the function as absent if the last read failed outright instead of returning a retry completion.

Top module: `rdy_poll_engine`

## Requirements
- R1: After reset, `status_o` is IDLE (0), `req_valid_o` is low, `progress_o` is low, `absent_o` is low and `elapsed_o` is 0.
- R2: An accepted start clears `elapsed_o` and sets `status_o` to BUSY (1). No read is requested until INIT_TICKS ticks (default 100) have been counted, and those ticks are included in `elapsed_o`.
- R3: A response is classified as follows. Low 16 bits equal to 0x0001 mean not ready yet, whatever the upper bits are. 0xFFFFFFFF means a failed read. Any other value is ready, and `status_o` becomes READY (2) with `elapsed_o` frozen.
- R4: After each not-ready response, the next wait is min(step, budget − elapsed). The step starts at 1 tick and doubles after every retry, so the total wait before the final read equals the budget. Ticks count toward `elapsed_o` only while a wait is running.
- R5: Readiness is tested before the budget. A ready response to the read that follows the last wait gives READY, not TIMEOUT.
- R6: A not-ready response once `elapsed_o` has reached the budget gives TIMEOUT (3). It also gives TIMEOUT when the settle period alone already exceeds the budget. `absent_o` is 1 exactly when that last response was 0xFFFFFFFF.
- R7: A `timeout_i` of 0 selects the default budget of 60000 ticks. Any other value is used as given and latched at start.
- R8: At most one read is outstanding. `req_valid_o` stays high until `req_ready_i` accepts it, and no new request is made until `rsp_valid_i` returns.
- R9: `progress_o` pulses for one cycle on each retry decision and never otherwise. At the first pulse, `elapsed_o` equals INIT_TICKS.
- R10: `start_i` is ignored while BUSY. Once READY or TIMEOUT is reached, the status and `elapsed_o` hold until the next start.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| timeout_i | input | TW | Budget in ticks; 0 selects the default |
| tick_i | input | 1 | Time base strobe |
| req_valid_o | output | 1 | Configuration read request |
| req_addr_o | output | AW | Register offset of the identifier word |
| req_ready_i | input | 1 | Request accepted |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 32 | Read response data |
| status_o | output | 2 | IDLE=0, BUSY=1, READY=2, TIMEOUT=3 |
| absent_o | output | 1 | Timeout with a failed last read |
| elapsed_o | output | TW | Ticks waited since start |
| progress_o | output | 1 | One-cycle pulse per retry |

## Verification
Any fault in the step register or in the budget cap shows up as a wrong `elapsed_o` at completion, and as a wrong read count, on the very first run that needs more than a couple of retries. A wrong response classifier or decision order shows up as the wrong final `status_o` within one cycle of the deciding response. This matters most in the case where the device is ready on the last read. A timer that counts ticks outside a wait shifts `elapsed_o` against the bench model on every run that uses a sparse tick.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_BUSY    = 2'd1,
      ST_READY   = 2'd2,
      ST_TIMEOUT = 2'd3
   } rpe_status_e;

   typedef enum logic [1:0] {
      PH_DELAY = 2'd0,
      PH_ISSUE = 2'd1,
      PH_WAIT  = 2'd2
   } rpe_phase_e;

   localparam logic [15:0] RETRY_TAG = 16'h0001;

   function automatic logic word_is_retry(input logic [31:0] d);
      return d[15:0] == RETRY_TAG;
   endfunction

   function automatic logic word_is_fail(input logic [31:0] d);
      return &d;
   endfunction
endpackage

// File: rtl/rpe_tick_timer.sv
module rpe_tick_timer #(
   parameter int TW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          clr_elapsed,
   input  logic          run,
   input  logic          tick,
   output logic          expire,
   output logic [TW-1:0] elapsed
);
   logic [TW-1:0] remain_q;
   logic          step_en;

   assign step_en = run && tick;
   assign expire  = step_en && (remain_q == TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_val;
      end else if (step_en && remain_q != '0) begin
         remain_q <= remain_q - TW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
      end else if (clr_elapsed) begin
         elapsed <= '0;
      end else if (step_en && elapsed != '1) begin
         elapsed <= elapsed + TW'(1);
      end
   end
endmodule

// File: rtl/rpe_backoff.sv
module rpe_backoff #(
   parameter int TW         = 20,
   parameter int FIRST_STEP = 1,
   parameter bit SATURATE   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          advance,
   input  logic [TW-1:0] elapsed,
   input  logic [TW-1:0] budget,
   output logic [TW-1:0] delay
);
   logic [TW-1:0] step_q;
   logic [TW-1:0] step_nx;
   logic [TW-1:0] left;

   generate
      if (SATURATE) begin : g_sat
         always_comb step_nx = step_q[TW-1] ? step_q : (step_q << 1);
      end else begin : g_wrap
         always_comb step_nx = (step_q << 1) | TW'(step_q[TW-1]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= TW'(FIRST_STEP);
      end else if (restart) begin
         step_q <= TW'(FIRST_STEP);
      end else if (advance) begin
         step_q <= step_nx;
      end
   end

   always_comb begin
      left  = (budget > elapsed) ? (budget - elapsed) : TW'(1);
      delay = (step_q < left) ? step_q : left;
   end
endmodule

// File: rtl/rdy_poll_engine.sv
module rdy_poll_engine
   import rpe_pkg::*;
#(
   parameter int          TW             = 20,
   parameter int          AW             = 12,
   parameter int          INIT_TICKS     = 100,
   parameter int          DEFAULT_BUDGET = 60000,
   parameter int          FIRST_STEP     = 1,
   parameter logic [11:0] ID_OFFSET      = 12'h000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [TW-1:0] timeout_i,
   input  logic          tick_i,
   output logic          req_valid_o,
   output logic [AW-1:0] req_addr_o,
   input  logic          req_ready_i,
   input  logic          rsp_valid_i,
   input  logic [31:0]   rsp_data_i,
   output logic [1:0]    status_o,
   output logic          absent_o,
   output logic [TW-1:0] elapsed_o,
   output logic          progress_o
);
   localparam logic [TW-1:0] INIT_W    = TW'(INIT_TICKS);
   localparam logic [TW-1:0] DEFAULT_W = TW'(DEFAULT_BUDGET);

   if (TW < 2) begin : g_bad_tw
      $error("TW too small");
   end
   if (INIT_TICKS < 1 || INIT_TICKS >= (2 ** TW) - 1) begin : g_bad_init
      $error("INIT_TICKS out of range");
   end
   if (DEFAULT_BUDGET < 1 || DEFAULT_BUDGET >= (2 ** TW)) begin : g_bad_def
      $error("DEFAULT_BUDGET out of range");
   end
   if (FIRST_STEP < 1) begin : g_bad_step
      $error("FIRST_STEP must be positive");
   end

   rpe_status_e   status_q;
   rpe_phase_e    phase_q;
   logic [TW-1:0] budget_q;
   logic          absent_q;
   logic          prog_q;

   logic          start_acc;
   logic          rsp_take;
   logic          rsp_good;
   logic          over_budget;
   logic          do_retry;
   logic          do_ready;
   logic          do_timeout;
   logic          timer_load;
   logic [TW-1:0] timer_val;
   logic          timer_run;
   logic          timer_exp;
   logic [TW-1:0] elapsed_w;
   logic [TW-1:0] delay_w;

   assign start_acc   = start_i && (status_q != ST_BUSY);
   assign rsp_take    = (status_q == ST_BUSY) && (phase_q == PH_WAIT) && rsp_valid_i;
   assign rsp_good    = !word_is_retry(rsp_data_i) && !word_is_fail(rsp_data_i);
   assign over_budget = elapsed_w >= budget_q;
   assign do_ready    = rsp_take && rsp_good;
   assign do_timeout  = rsp_take && !rsp_good && over_budget;
   assign do_retry    = rsp_take && !rsp_good && !over_budget;

   assign timer_load = start_acc || do_retry;
   assign timer_val  = start_acc ? INIT_W : delay_w;
   assign timer_run  = (status_q == ST_BUSY) && (phase_q == PH_DELAY);

   rpe_tick_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (timer_load),
      .load_val   (timer_val),
      .clr_elapsed(start_acc),
      .run        (timer_run),
      .tick       (tick_i),
      .expire     (timer_exp),
      .elapsed    (elapsed_w)
   );

   rpe_backoff #(.TW(TW), .FIRST_STEP(FIRST_STEP), .SATURATE(1'b1)) u_backoff (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(start_acc),
      .advance(do_retry),
      .elapsed(elapsed_w),
      .budget (budget_q),
      .delay  (delay_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= ST_IDLE;
         phase_q  <= PH_DELAY;
         budget_q <= '0;
         absent_q <= 1'b0;
         prog_q   <= 1'b0;
      end else begin
         prog_q <= do_retry;
         if (start_acc) begin
            status_q <= ST_BUSY;
            phase_q  <= PH_DELAY;
            absent_q <= 1'b0;
            budget_q <= (timeout_i == '0) ? DEFAULT_W : timeout_i;
         end else if (status_q == ST_BUSY) begin
            unique case (phase_q)
               PH_DELAY: if (timer_exp) phase_q <= PH_ISSUE;
               PH_ISSUE: if (req_ready_i) phase_q <= PH_WAIT;
               PH_WAIT: begin
                  if (do_ready) begin
                     status_q <= ST_READY;
                  end else if (do_timeout) begin
                     status_q <= ST_TIMEOUT;
                     absent_q <= word_is_fail(rsp_data_i);
                  end else if (do_retry) begin
                     phase_q <= PH_DELAY;
                  end
               end
               default: phase_q <= PH_DELAY;
            endcase
         end
      end
   end

   assign req_valid_o = (status_q == ST_BUSY) && (phase_q == PH_ISSUE);
   assign req_addr_o  = AW'(ID_OFFSET);
   assign status_o    = status_q;
   assign absent_o    = absent_q;
   assign elapsed_o   = elapsed_w;
   assign progress_o  = prog_q;
endmodule

// File: rtl/rpe_checker.sv
module rpe_checker #(
   parameter int TW         = 20,
   parameter int INIT_TICKS = 100
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          req_valid_o,
   input logic          req_ready_i,
   input logic          rsp_valid_i,
   input logic [1:0]    status_o,
   input logic [TW-1:0] elapsed_o,
   input logic          progress_o
);
   logic pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= 1'b0;
      else if (req_valid_o && req_ready_i) pending_q <= 1'b1;
      else if (rsp_valid_i) pending_q <= 1'b0;
   end

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> req_valid_o);

   assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q |-> !req_valid_o);

   assert_settle_before_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (elapsed_o >= TW'(INIT_TICKS)));

   assert_progress_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      progress_o |-> (status_o == 2'd1));

   assert_busy_no_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'd1) |=> (status_o != 2'd0));

   assert_elapsed_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'd1) |=> ((status_o != 2'd1) || (elapsed_o >= $past(elapsed_o))));

   assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o[1]) && !start_i) |=> ($stable(status_o) && $stable(elapsed_o)));
endmodule

bind rdy_poll_engine rpe_checker #(.TW(TW), .INIT_TICKS(INIT_TICKS)) u_rpe_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .req_valid_o(req_valid_o),
   .req_ready_i(req_ready_i),
   .rsp_valid_i(rsp_valid_i),
   .status_o   (status_o),
   .elapsed_o  (elapsed_o),
   .progress_o (progress_o)
);

// File: tb/rdy_poll_engine_test.sv
module rdy_poll_engine_test;
   localparam int TW = 20;
   localparam int AW = 12;
   localparam int INIT = 100;
   localparam int DEF = 60000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [TW-1:0] timeout_i = '0;
   logic          tick_i = 1'b0;
   logic          req_valid_o;
   logic [AW-1:0] req_addr_o;
   logic          req_ready_i = 1'b0;
   logic          rsp_valid_i = 1'b0;
   logic [31:0]   rsp_data_i = '0;
   logic [1:0]    status_o;
   logic          absent_o;
   logic [TW-1:0] elapsed_o;
   logic          progress_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   int   dev_ready_idx = -1;
   bit   dev_fail = 1'b0;
   int   dev_reads = 0;
   int   dev_ph = 0;
   int   dev_cnt = 0;
   logic [31:0] dev_word = 32'h1234_8086;
   bit   tick_dense = 1'b0;
   int   prog_cnt = 0;
   int   first_prog_el = -1;

   always #2.5 clk = ~clk;

   rdy_poll_engine #(.TW(TW), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
      .tick_i(tick_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
      .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
      .status_o(status_o), .absent_o(absent_o), .elapsed_o(elapsed_o),
      .progress_o(progress_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         finish_run();
      end
   end

   // time base and device model, driven on the falling edge
   always @(negedge clk) begin
      tick_i = tick_dense ? 1'b1 : (($urandom % 3) != 0);
      if (progress_o) begin
         if (prog_cnt == 0) first_prog_el = int'(elapsed_o);
         prog_cnt++;
      end
      case (dev_ph)
         0: if (req_valid_o) begin
               if (dev_cnt == 0) begin
                  req_ready_i = 1'b1;
                  dev_ph = 1;
               end else dev_cnt--;
            end
         1: begin
               req_ready_i = 1'b0;
               dev_cnt = $urandom % 4;
               dev_ph = 2;
            end
         2: if (dev_cnt == 0) begin
               rsp_valid_i = 1'b1;
               if (dev_reads == dev_ready_idx) rsp_data_i = dev_word;
               else if (dev_fail) rsp_data_i = 32'hFFFF_FFFF;
               else rsp_data_i = {16'($urandom), 16'h0001};
               dev_reads++;
               dev_ph = 3;
            end else dev_cnt--;
         default: begin
               rsp_valid_i = 1'b0;
               rsp_data_i = '0;
               dev_cnt = $urandom % 3;
               dev_ph = 0;
            end
      endcase
   end

   // model of R4..R7: outcome, elapsed and read count
   function automatic void model(input int to, input int ri,
                                 output int st, output int el, output int nr);
      int bud = (to == 0) ? DEF : to;
      int step = 1;
      int n = 0;
      el = INIT;
      forever begin
         if (n == ri) begin st = 2; nr = n + 1; return; end
         if (el >= bud) begin st = 3; nr = n + 1; return; end
         el += (step < bud - el) ? step : bud - el;
         step *= 2;
         n++;
      end
   endfunction

   task automatic run_case(input string tag, input int to, input int ri,
                           input bit fail, input logic [31:0] word,
                           input bit inject);
      int st, el, nr;
      model(to, ri, st, el, nr);
      @(negedge clk);
      dev_ready_idx = ri; dev_fail = fail; dev_word = word;
      dev_reads = 0; prog_cnt = 0; first_prog_el = -1;
      timeout_i = TW'(to);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check({tag, " R2 busy after start"}, int'(status_o), 1);
      if (inject) begin
         repeat (30) @(negedge clk);
         timeout_i = TW'(7);
         start_i = 1'b1;           // R10: must be ignored
         @(negedge clk);
         start_i = 1'b0;
         check({tag, " R10 start ignored"}, int'(status_o), 1);
      end
      while (status_o == 2'd1) @(negedge clk);
      check({tag, " R3/R5/R6 status"}, int'(status_o), st);
      check({tag, " R4 elapsed"}, int'(elapsed_o), el);
      check({tag, " R4 reads"}, dev_reads, nr);
      check({tag, " R9 progress"}, prog_cnt, nr - 1);
      if (nr > 1) check({tag, " R9 first progress elapsed"}, first_prog_el, INIT);
      check({tag, " R6 absent"}, int'(absent_o), (st == 3 && fail) ? 1 : 0);
      repeat (5) @(negedge clk);
      check({tag, " R10 hold"}, int'(status_o), st);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1 status", int'(status_o), 0);
      check("R1 req", int'(req_valid_o), 0);
      check("R1 elapsed", int'(elapsed_o), 0);
      check("R1 absent", int'(absent_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 progress", int'(progress_o), 0);

      run_case("ready4", 300, 3, 0, 32'h1234_8086, 0);
      run_case("retry_to", 300, -1, 0, 32'h0, 0);
      run_case("absent", 300, -1, 1, 32'h0, 0);
      run_case("R5 last", 300, 8, 0, 32'h5555_10EE, 0);
      run_case("R5 last fail", 300, 8, 1, 32'hFFFF_1234, 0);
      run_case("short", 50, -1, 0, 32'h0, 0);
      run_case("first ok", 300, 0, 1, 32'h0000_0000, 0);
      run_case("inject", 400, 6, 0, 32'hABCD_0002, 1);
      for (int i = 0; i < 16; i++) begin
         int to = 100 + int'($urandom % 1900);
         int ri = int'($urandom % 12) - 1;
         run_case("rand", to, ri, bit'($urandom % 2), {$urandom} | 32'h2, 0);
      end
      tick_dense = 1'b1;
      run_case("R7 default", 0, -1, 0, 32'h0, 0);
      finish_run();
   end
endmodule